// File: doc/BRIEF.md
# Dual-Lane Poll and Status-Read Scheduler

This block paces the housekeeping traffic of a two-lane serial side channel. It produces two kinds of periodic request strobes, poll and status-read, for each of two lanes. Each kind has its own interval, set by a 2-bit coarse field and an 8-bit fine field. The interval is measured in oscillator ticks, where a tick is a one-cycle enable on `osc_tick`, and its length is 64 × (256 × coarse + fine + 1) ticks. A kind whose two fields are both zero is switched off.

A lane receives a strobe of a given kind only when its link enable and that kind's lane enable are both set. Lane 1 normally polls in the same cycle as lane 0. With `lag_en` set, lane 1 polls a quarter of the poll interval after lane 0. Any change to a kind's interval fields restarts that kind's count, so the next strobe comes one full new interval after the change. The protocol engine that acts on the strobes lies outside this block.

Top module: `dual_lane_poll_sched`

## Requirements
- R1: With poll fields UP (`poll_up`) and DN (`poll_dn`) not both zero, lane 0 poll strobes repeat every 64 × (256 × UP + DN + 1) oscillator ticks.
- R2: Status-read strobes follow the same formula using `ssr_up` and `ssr_dn`, independently of the poll fields.
- R3: When both fields of a kind are zero, no strobe of that kind is issued on either lane.
- R4: A lane's strobe of a kind appears only if `link_en[lane]` and that kind's enable bit (`poll_en[lane]` or `ssr_en[lane]`) are both 1. Bit 0 is lane 0 and bit 1 is lane 1.
- R5: With `lag_en` = 0, lane 1 poll strobes coincide with lane 0 poll strobes. With `lag_en` = 1, each lane 1 poll strobe comes 16 × (256 × UP + DN + 1) ticks after the start of the period. The period starts at a lane 0 poll strobe or at a restart.
- R6: A change of a kind's interval fields is seen on the next clock edge and restarts that kind's count. The first strobe is then visible P + 1 clock edges after the change is driven, where P is the new interval in ticks and a tick occurs every cycle.
- R7: Every strobe is exactly one clock cycle wide.
- R8: Only cycles with `osc_tick` = 1 advance the interval. A strobe follows only a cycle in which `osc_tick` was 1.
- R9: While `rst_n` is low, all strobe outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle oscillator tick enable |
| poll_up | input | 2 | Poll interval coarse field |
| poll_dn | input | 8 | Poll interval fine field |
| ssr_up | input | 2 | Status-read interval coarse field |
| ssr_dn | input | 8 | Status-read interval fine field |
| lag_en | input | 1 | Delay lane 1 poll by a quarter interval |
| link_en | input | 2 | Per-lane link enable |
| poll_en | input | 2 | Per-lane poll enable |
| ssr_en | input | 2 | Per-lane status-read enable |
| poll_stb | output | 2 | Per-lane poll strobe |
| ssr_stb | output | 2 | Per-lane status-read strobe |

## Verification
The assertions check on every cycle the properties that hold locally in time. These are strobe width, gating by the lane enables, silence when a kind is switched off or after a cycle without a tick, and lane alignment while the lag is off. Only the bench scenarios can show the actual interval lengths. They measure edge counts for the fine field, the coarse field and a sparse tick, the quarter-period lag of lane 1, and the restart that follows a change to the interval fields.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int LANES      = 2;
    localparam int COARSE_W   = 2;
    localparam int FINE_W     = 8;
    localparam int SUB_W      = 6;
    localparam int KINDS      = 2;

    typedef enum logic {KIND_POLL = 1'b0, KIND_SSR = 1'b1} req_kind_e;
endpackage

// File: rtl/interval_timer.sv
module interval_timer
    import sched_pkg::*;
#(
    parameter int COARSE_BITS = COARSE_W,
    parameter int FINE_BITS   = FINE_W,
    parameter int SUB_BITS    = SUB_W,
    parameter int HAS_LAG     = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [COARSE_BITS-1:0] coarse,
    input  logic [FINE_BITS-1:0]   fine,
    input  logic                   lag_req,
    output logic [LANES-1:0]       hit
);
    localparam int CFG_BITS = COARSE_BITS + FINE_BITS;
    localparam int CNT_BITS = CFG_BITS + SUB_BITS;
    localparam int LAG_SH   = SUB_BITS - 2;

    typedef struct packed {
        logic [CNT_BITS-1:0]  cnt;
        logic [CFG_BITS-1:0]  cfg;
        logic [LANES-1:0]     hit;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic [CFG_BITS-1:0] cfg_now;
    logic [CNT_BITS-1:0] last_tick;
    logic [CNT_BITS-1:0] span;
    logic [CNT_BITS-1:0] lag_tick;
    logic                lag_on;
    logic                at_end;

    always_comb begin
        cfg_now   = {coarse, fine};
        last_tick = {cfg_now, {SUB_BITS{1'b1}}};
        span      = CNT_BITS'(cfg_now) + CNT_BITS'(1);
        lag_tick  = (span << LAG_SH) - CNT_BITS'(1);
        lag_on    = (HAS_LAG != 0) && lag_req;
        at_end    = (st_q.cnt == last_tick);

        st_d     = st_q;
        st_d.hit = '0;
        if (cfg_now != st_q.cfg) begin
            st_d.cfg = cfg_now;
            st_d.cnt = '0;
        end else if (cfg_now == '0) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt    = at_end ? '0 : st_q.cnt + CNT_BITS'(1);
            st_d.hit[0] = at_end;
            for (int ln = 1; ln < LANES; ln++) begin
                st_d.hit[ln] = lag_on ? (st_q.cnt == lag_tick) : at_end;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit = st_q.hit;
endmodule

// File: rtl/lane_gate.sv
module lane_gate
    import sched_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic [NLANES-1:0] hit,
    input  logic [NLANES-1:0] link_on,
    input  logic [NLANES-1:0] req_on,
    output logic [NLANES-1:0] stb
);
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign stb[g] = hit[g] & link_on[g] & req_on[g];
    end
endmodule

// File: rtl/dual_lane_poll_sched.sv
module dual_lane_poll_sched
    import sched_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                osc_tick,
    input  logic [COARSE_W-1:0] poll_up,
    input  logic [FINE_W-1:0]   poll_dn,
    input  logic [COARSE_W-1:0] ssr_up,
    input  logic [FINE_W-1:0]   ssr_dn,
    input  logic                lag_en,
    input  logic [LANES-1:0]    link_en,
    input  logic [LANES-1:0]    poll_en,
    input  logic [LANES-1:0]    ssr_en,
    output logic [LANES-1:0]    poll_stb,
    output logic [LANES-1:0]    ssr_stb
);
    logic [COARSE_W-1:0] coarse_k [KINDS];
    logic [FINE_W-1:0]   fine_k   [KINDS];
    logic [LANES-1:0]    en_k     [KINDS];
    logic [LANES-1:0]    hit_k    [KINDS];
    logic [LANES-1:0]    stb_k    [KINDS];
    logic                lag_k    [KINDS];

    always_comb begin
        coarse_k[KIND_POLL] = poll_up;
        fine_k[KIND_POLL]   = poll_dn;
        en_k[KIND_POLL]     = poll_en;
        lag_k[KIND_POLL]    = lag_en;
        coarse_k[KIND_SSR]  = ssr_up;
        fine_k[KIND_SSR]    = ssr_dn;
        en_k[KIND_SSR]      = ssr_en;
        lag_k[KIND_SSR]     = 1'b0;
    end

    for (genvar k = 0; k < KINDS; k++) begin : g_kind
        interval_timer #(
            .COARSE_BITS(COARSE_W),
            .FINE_BITS  (FINE_W),
            .SUB_BITS   (SUB_W),
            .HAS_LAG    ((k == int'(KIND_POLL)) ? 1 : 0)
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (osc_tick),
            .coarse (coarse_k[k]),
            .fine   (fine_k[k]),
            .lag_req(lag_k[k]),
            .hit    (hit_k[k])
        );

        lane_gate #(.NLANES(LANES)) u_gate (
            .hit    (hit_k[k]),
            .link_on(link_en),
            .req_on (en_k[k]),
            .stb    (stb_k[k])
        );
    end

    assign poll_stb = stb_k[KIND_POLL];
    assign ssr_stb  = stb_k[KIND_SSR];
endmodule

// File: rtl/dual_lane_poll_sched_chk.sv
module dual_lane_poll_sched_chk
    import sched_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                osc_tick,
    input logic [COARSE_W-1:0] poll_up,
    input logic [FINE_W-1:0]   poll_dn,
    input logic [COARSE_W-1:0] ssr_up,
    input logic [FINE_W-1:0]   ssr_dn,
    input logic                lag_en,
    input logic [LANES-1:0]    link_en,
    input logic [LANES-1:0]    poll_en,
    input logic [LANES-1:0]    ssr_en,
    input logic [LANES-1:0]    poll_stb,
    input logic [LANES-1:0]    ssr_stb
);
    // R7
    poll0_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_stb[0] |=> !poll_stb[0]);
    // R7
    poll1_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_stb[1] |=> !poll_stb[1]);
    // R7
    ssr0_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssr_stb[0] |=> !ssr_stb[0]);
    // R7
    ssr1_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssr_stb[1] |=> !ssr_stb[1]);
    // R4
    poll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_stb & ~(link_en & poll_en)) == '0);
    // R4
    ssr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ssr_stb & ~(link_en & ssr_en)) == '0);
    // R3
    poll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({poll_up, poll_dn} == '0) |=> (poll_stb == '0));
    // R3
    ssr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({ssr_up, ssr_dn} == '0) |=> (ssr_stb == '0));
    // R8
    no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> (poll_stb == '0 && ssr_stb == '0));
    // R5
    lane_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lag_en && link_en == 2'b11 && poll_en == 2'b11)
            |=> ((link_en != 2'b11) || (poll_en != 2'b11) || (poll_stb[0] == poll_stb[1])));
    // R9
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (poll_stb == '0 && ssr_stb == '0);
        end
    end
endmodule

bind dual_lane_poll_sched dual_lane_poll_sched_chk u_chk (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .poll_up(poll_up), .poll_dn(poll_dn), .ssr_up(ssr_up), .ssr_dn(ssr_dn),
    .lag_en(lag_en), .link_en(link_en), .poll_en(poll_en), .ssr_en(ssr_en),
    .poll_stb(poll_stb), .ssr_stb(ssr_stb)
);

// File: tb/dual_lane_poll_sched_test.sv
module dual_lane_poll_sched_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_alt = 1'b0;
    logic       alt_q = 1'b0;
    logic       osc_tick;
    logic [1:0] poll_up = 2'd0;
    logic [7:0] poll_dn = 8'd1;
    logic [1:0] ssr_up = 2'd0;
    logic [7:0] ssr_dn = 8'd3;
    logic       lag_en = 1'b0;
    logic [1:0] link_en = 2'b11;
    logic [1:0] poll_en = 2'b11;
    logic [1:0] ssr_en = 2'b11;
    logic [1:0] poll_stb;
    logic [1:0] ssr_stb;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    always @(negedge clk) alt_q <= ~alt_q;
    assign osc_tick = tick_alt ? alt_q : 1'b1;

    dual_lane_poll_sched uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .poll_up(poll_up), .poll_dn(poll_dn), .ssr_up(ssr_up), .ssr_dn(ssr_dn),
        .lag_en(lag_en), .link_en(link_en), .poll_en(poll_en), .ssr_en(ssr_en),
        .poll_stb(poll_stb), .ssr_stb(ssr_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit sig(input int which);
        case (which)
            0: return poll_stb[0];
            1: return poll_stb[1];
            2: return ssr_stb[0];
            default: return ssr_stb[1];
        endcase
    endfunction

    // counts clock edges from the current negedge until the chosen strobe is seen
    task automatic edges_to(input int which, output int n);
        n = 0;
        forever begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (sig(which) || n > 70000) break;
        end
    endtask

    task automatic count_in(input int which, input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (sig(which)) hits++;
        end
    endtask

    task automatic t_reset;
        int seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (poll_stb != 0 || ssr_stb != 0) seen++;
        end
        chk(seen == 0, "R9 outputs low in reset", seen, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_poll_period;
        int n;
        @(negedge clk);
        poll_up = 2'd0; poll_dn = 8'd5;
        edges_to(0, n);
        chk(n == 385, "R6 first poll after write", n, 385);
        edges_to(0, n);
        chk(n == 384, "R1 poll period fine field", n, 384);
        chk(poll_stb[1] == 1'b1, "R5 lane1 aligned without lag", poll_stb[1], 1);
        @(negedge clk);
        chk(poll_stb == 2'b00, "R7 poll strobe one cycle", poll_stb, 0);
        poll_up = 2'd1; poll_dn = 8'd0;
        edges_to(0, n);
        chk(n == 16449, "R1 poll period coarse field", n, 16449);
    endtask

    task automatic t_ssr;
        int n;
        @(negedge clk);
        ssr_up = 2'd0; ssr_dn = 8'd3;
        poll_up = 2'd0; poll_dn = 8'd1;
        edges_to(2, n);
        edges_to(2, n);
        chk(n == 256, "R2 ssr period", n, 256);
        chk(ssr_stb[1] == 1'b1, "R2 ssr lane1 same cycle", ssr_stb[1], 1);
        @(negedge clk);
        chk(ssr_stb == 2'b00, "R7 ssr strobe one cycle", ssr_stb, 0);
    endtask

    task automatic t_zero;
        int h;
        @(negedge clk);
        poll_up = 2'd0; poll_dn = 8'd0;
        count_in(0, 2000, h);
        chk(h == 0, "R3 poll off lane0", h, 0);
        poll_dn = 8'd0;
        count_in(1, 600, h);
        chk(h == 0, "R3 poll off lane1", h, 0);
        count_in(2, 600, h);
        chk(h >= 2, "R3 ssr unaffected", h, 2);
        poll_dn = 8'd1;
    endtask

    task automatic t_gate;
        int h;
        @(negedge clk);
        link_en = 2'b01; poll_en = 2'b11;
        count_in(1, 600, h);
        chk(h == 0, "R4 link off blocks lane1", h, 0);
        count_in(0, 600, h);
        chk(h >= 3, "R4 lane0 still polls", h, 3);
        link_en = 2'b11; poll_en = 2'b10;
        count_in(0, 600, h);
        chk(h == 0, "R4 poll_en off blocks lane0", h, 0);
        count_in(1, 600, h);
        chk(h >= 3, "R4 lane1 polls", h, 3);
        ssr_en = 2'b01;
        count_in(3, 600, h);
        chk(h == 0, "R4 ssr_en off blocks lane1", h, 0);
        poll_en = 2'b11; ssr_en = 2'b11;
    endtask

    task automatic t_offset;
        int n;
        @(negedge clk);
        lag_en = 1'b1; poll_up = 2'd0; poll_dn = 8'd3;
        edges_to(1, n);
        chk(n == 65, "R5 first lagged lane1", n, 65);
        chk(poll_stb[0] == 1'b0, "R5 lane0 quiet at lag point", poll_stb[0], 0);
        edges_to(0, n);
        chk(n == 192, "R5 lane0 after lane1", n, 192);
        edges_to(1, n);
        chk(n == 64, "R5 quarter lag", n, 64);
        lag_en = 1'b0;
    endtask

    task automatic t_restart;
        int n;
        @(negedge clk);
        poll_up = 2'd0; poll_dn = 8'd7;
        repeat (300) @(negedge clk);
        poll_dn = 8'd1;
        edges_to(0, n);
        chk(n == 129, "R6 restart on new interval", n, 129);
    endtask

    task automatic t_tick;
        int n;
        @(negedge clk);
        tick_alt = 1'b1;
        poll_up = 2'd0; poll_dn = 8'd2;
        edges_to(0, n);
        edges_to(0, n);
        chk(n == 384, "R8 half-rate ticks double period", n, 384);
        tick_alt = 1'b0;
    endtask

    initial begin
        t_reset();
        t_poll_period();
        t_ssr();
        t_zero();
        t_gate();
        t_offset();
        t_restart();
        t_tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1500000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule